// File: doc/BRIEF.md
# SCSI Initiator Phase and Handshake Controller

This block runs the bus side of a block move on a parallel SCSI bus. An instruction executor gives it a requested information phase and a byte count, then pulses a start strobe. In initiator mode the block compares the requested phase with the phase lines it has sampled from the target. If they differ, it raises a mismatch pulse and moves nothing. If they agree, it runs one REQ/ACK handshake per byte. It captures bytes in inbound phases and drives the data bus in outbound phases. A done pulse follows the last handshake. In target mode the block drives the three phase lines to the requested code and reports completion at once.

Two message-phase rules apply to the last byte. In Message-Out, the attention line is released on the same clock edge that ACK is raised for the final byte. In Message-In, ACK is left asserted after the final byte. It stays asserted until the executor pulses the clear-ACK command, which gives firmware time to decide whether to reject the message. Attention is raised by a set-attention pulse. The executor pulses that input both for its explicit set command and for a selection with attention.

All bus inputs pass through one register stage before any decision is taken. All outputs are registered.

Top module: `scsi_phase_xfer`

## Requirements
- R1: A phase is coded as {MSG, C/D, I/O}: 000 Data-Out, 001 Data-In, 010 Command, 011 Status, 100/101 reserved out/in, 110 Message-Out, 111 Message-In. In initiator mode, a start whose requested code differs from the sampled phase lines gives a one-cycle `mismatch` pulse, and ACK is not asserted.
- R2: Each byte follows one sequence: wait for sampled REQ high, raise ACK, wait for sampled REQ low, drop ACK. ACK never rises while REQ is low.
- R3: In a phase with I/O = 1, the sampled data byte is presented on `rx_data` with a one-cycle `rx_valid` pulse on the edge where ACK rises.
- R4: `bus_data_oe` is high only during a transfer in a phase with I/O = 0. There `bus_data_o` carries `tx_data` when ACK rises, and `tx_taken` pulses on that edge.
- R5: `done` pulses once, after the programmed number of handshakes completes. A count of zero gives `done` on the cycle after start, with no handshake.
- R6: A `set_atn` pulse raises `bus_atn_o`. During a Message-Out transfer, ATN falls on the same edge that ACK rises for the final byte, and it stays high for the earlier bytes.
- R7: After the final Message-In byte, ACK stays asserted until a `clear_ack` pulse. It drops on the next edge after that pulse.
- R8: A start with `target_mode` high drives `bus_msg_o`, `bus_cd_o` and `bus_io_o` to the requested code, sets `bus_phase_oe`, pulses `done`, and raises no ACK.
- R9: After reset, ACK, ATN, both output enables, `done`, `mismatch` and `rx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a move |
| target_mode | input | 1 | 1: drive phase lines; 0: initiator transfer |
| req_phase | input | 3 | Requested phase {MSG, C/D, I/O} |
| byte_count | input | CNT_W | Number of handshakes to run |
| set_atn | input | 1 | Raise attention (set command or selection with attention) |
| clear_ack | input | 1 | Release an ACK held after Message-In |
| tx_data | input | DATA_W | Next outbound byte |
| tx_taken | output | 1 | Outbound byte consumed |
| rx_data | output | DATA_W | Captured inbound byte |
| rx_valid | output | 1 | rx_data valid pulse |
| done | output | 1 | Move finished pulse |
| mismatch | output | 1 | Phase mismatch pulse |
| bus_req_i | input | 1 | REQ from target |
| bus_msg_i | input | 1 | MSG line |
| bus_cd_i | input | 1 | C/D line |
| bus_io_i | input | 1 | I/O line |
| bus_data_i | input | DATA_W | Data lines in |
| bus_ack_o | output | 1 | ACK to target |
| bus_atn_o | output | 1 | ATN to target |
| bus_msg_o | output | 1 | MSG driven in target mode |
| bus_cd_o | output | 1 | C/D driven in target mode |
| bus_io_o | output | 1 | I/O driven in target mode |
| bus_phase_oe | output | 1 | Enable for the three phase lines |
| bus_data_o | output | DATA_W | Data lines out |
| bus_data_oe | output | 1 | Enable for the data lines |

## Verification
Start-driven results are due one edge after the start strobe:
- `mismatch`, the zero-count `done`, and the target-mode `done` and phase lines all appear there. The bench samples them on the following falling edge.

Bus-driven results are due two edges after the target model changes REQ, because of the input register:
- ACK rises (with `rx_valid`, `tx_taken` and, for the final Message-Out byte, the ATN drop) on that edge.

The target model therefore waits on the ACK level itself, one falling edge at a time, rather than counting cycles. It reads the data and ATN values in the same half-cycle that it first sees ACK high. A queue-based monitor matches each `rx_valid`, `done` and `mismatch` pulse in order against the expected items queued by the driver.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

  typedef enum logic [2:0] {
    PH_DATA_OUT = 3'b000,
    PH_DATA_IN  = 3'b001,
    PH_COMMAND  = 3'b010,
    PH_STATUS   = 3'b011,
    PH_RSV_OUT  = 3'b100,
    PH_RSV_IN   = 3'b101,
    PH_MSG_OUT  = 3'b110,
    PH_MSG_IN   = 3'b111
  } phase_e;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT_REQ,
    HS_WAIT_REL
  } hs_state_e;

  // I/O bit set: target drives the data lines
  function automatic logic phase_inbound(input logic [2:0] ph);
    return ph[0];
  endfunction

endpackage

// File: rtl/scsi_bus_sampler.sv
module scsi_bus_sampler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [2:0]        phase_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_s,
  output logic [2:0]        phase_s,
  output logic [DATA_W-1:0] data_s
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_s   <= 1'b0;
      phase_s <= '0;
      data_s  <= '0;
    end else begin
      req_s   <= req_i;
      phase_s <= phase_i;
      data_s  <= data_i;
    end
  end

endmodule

// File: rtl/scsi_atn_ctrl.sv
module scsi_atn_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_atn,
  input  logic drop_atn,
  output logic atn_o
);

  always_ff @(posedge clk) begin
    if (rst)           atn_o <= 1'b0;
    else if (drop_atn) atn_o <= 1'b0;
    else if (set_atn)  atn_o <= 1'b1;
  end

  // R6
  atn_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(atn_o) |-> $past(set_atn));

  // R6
  atn_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(atn_o) |-> $past(drop_atn));

endmodule

// File: rtl/scsi_hs_fsm.sv
module scsi_hs_fsm
  import scsi_xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              target_mode,
  input  logic [2:0]        req_phase,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              clear_ack,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              req_s,
  input  logic [2:0]        phase_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              ack_o,
  output logic              drop_atn,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_taken,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic [2:0]        phase_o,
  output logic              phase_oe,
  output logic              done,
  output logic              mismatch
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  hs_state_e        state;
  logic [CNT_W-1:0] remain;
  logic [2:0]       cur_phase;
  logic             last_byte;

  assign last_byte = (remain == ONE);
  assign drop_atn  = (state == HS_WAIT_REQ) && req_s && last_byte &&
                     (cur_phase == PH_MSG_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HS_IDLE;
      remain    <= '0;
      cur_phase <= '0;
      ack_o     <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      tx_taken  <= 1'b0;
      data_o    <= '0;
      data_oe   <= 1'b0;
      phase_o   <= '0;
      phase_oe  <= 1'b0;
      done      <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
      done     <= 1'b0;
      mismatch <= 1'b0;
      case (state)
        HS_IDLE: begin
          data_oe <= 1'b0;
          if (clear_ack) ack_o <= 1'b0;
          if (start) begin
            if (target_mode) begin
              phase_o  <= req_phase;
              phase_oe <= 1'b1;
              done     <= 1'b1;
            end else begin
              phase_oe <= 1'b0;
              if (phase_s != req_phase) begin
                mismatch <= 1'b1;
              end else if (byte_count == '0) begin
                done <= 1'b1;
              end else begin
                remain    <= byte_count;
                cur_phase <= req_phase;
                state     <= HS_WAIT_REQ;
              end
            end
          end
        end
        HS_WAIT_REQ: begin
          data_oe <= !phase_inbound(cur_phase);
          data_o  <= tx_data;
          if (req_s) begin
            ack_o <= 1'b1;
            if (phase_inbound(cur_phase)) begin
              rx_data  <= data_s;
              rx_valid <= 1'b1;
            end else begin
              tx_taken <= 1'b1;
            end
            state <= HS_WAIT_REL;
          end
        end
        HS_WAIT_REL: begin
          if (!req_s) begin
            if (last_byte) begin
              done  <= 1'b1;
              state <= HS_IDLE;
              if (cur_phase != PH_MSG_IN) ack_o <= 1'b0;
            end else begin
              ack_o  <= 1'b0;
              remain <= remain - ONE;
              state  <= HS_WAIT_REQ;
            end
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(req_s));

  // R2
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> (!$past(req_s) || $past(clear_ack)));

  // R1
  mismatch_noack_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch |-> $stable(ack_o));

  // R4
  rx_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !data_oe);

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && mismatch));

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == HS_IDLE && ack_o && !clear_ack && !start) |=> ack_o);

  // R8
  tgt_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_oe) |-> done);

endmodule

// File: rtl/scsi_phase_xfer.sv
module scsi_phase_xfer
  import scsi_xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              target_mode,
  input  logic [2:0]        req_phase,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              set_atn,
  input  logic              clear_ack,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_taken,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              done,
  output logic              mismatch,
  input  logic              bus_req_i,
  input  logic              bus_msg_i,
  input  logic              bus_cd_i,
  input  logic              bus_io_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_ack_o,
  output logic              bus_atn_o,
  output logic              bus_msg_o,
  output logic              bus_cd_o,
  output logic              bus_io_o,
  output logic              bus_phase_oe,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe
);

  logic              req_s;
  logic [2:0]        phase_s;
  logic [DATA_W-1:0] data_s;
  logic              drop_atn;
  logic [2:0]        phase_drv;

  scsi_bus_sampler #(.DATA_W(DATA_W)) u_sample (
    .clk     (clk),
    .rst     (rst),
    .req_i   (bus_req_i),
    .phase_i ({bus_msg_i, bus_cd_i, bus_io_i}),
    .data_i  (bus_data_i),
    .req_s   (req_s),
    .phase_s (phase_s),
    .data_s  (data_s)
  );

  scsi_hs_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .target_mode (target_mode),
    .req_phase   (req_phase),
    .byte_count  (byte_count),
    .clear_ack   (clear_ack),
    .tx_data     (tx_data),
    .req_s       (req_s),
    .phase_s     (phase_s),
    .data_s      (data_s),
    .ack_o       (bus_ack_o),
    .drop_atn    (drop_atn),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .tx_taken    (tx_taken),
    .data_o      (bus_data_o),
    .data_oe     (bus_data_oe),
    .phase_o     (phase_drv),
    .phase_oe    (bus_phase_oe),
    .done        (done),
    .mismatch    (mismatch)
  );

  scsi_atn_ctrl u_atn (
    .clk      (clk),
    .rst      (rst),
    .set_atn  (set_atn),
    .drop_atn (drop_atn),
    .atn_o    (bus_atn_o)
  );

  assign {bus_msg_o, bus_cd_o, bus_io_o} = phase_drv;

  // R6
  atn_drop_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_atn_o) |-> $rose(bus_ack_o));

endmodule

// File: tb/tb_scsi_phase_xfer.sv
module tb_scsi_phase_xfer;

  localparam int CNT_W  = 24;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, target_mode = 1'b0, set_atn = 1'b0, clear_ack = 1'b0;
  logic [2:0] req_phase = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_taken, rx_valid, done, mismatch;
  logic [DATA_W-1:0] rx_data;
  logic bus_req_i = 1'b0, bus_msg_i = 1'b0, bus_cd_i = 1'b0, bus_io_i = 1'b0;
  logic [DATA_W-1:0] bus_data_i = '0;
  logic bus_ack_o, bus_atn_o, bus_msg_o, bus_cd_o, bus_io_o, bus_phase_oe, bus_data_oe;
  logic [DATA_W-1:0] bus_data_o;

  always #10 clk = ~clk;

  scsi_phase_xfer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .start(start), .target_mode(target_mode),
    .req_phase(req_phase), .byte_count(byte_count), .set_atn(set_atn),
    .clear_ack(clear_ack), .tx_data(tx_data), .tx_taken(tx_taken),
    .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .mismatch(mismatch),
    .bus_req_i(bus_req_i), .bus_msg_i(bus_msg_i), .bus_cd_i(bus_cd_i),
    .bus_io_i(bus_io_i), .bus_data_i(bus_data_i), .bus_ack_o(bus_ack_o),
    .bus_atn_o(bus_atn_o), .bus_msg_o(bus_msg_o), .bus_cd_o(bus_cd_o),
    .bus_io_o(bus_io_o), .bus_phase_oe(bus_phase_oe), .bus_data_o(bus_data_o),
    .bus_data_oe(bus_data_oe)
  );

  typedef struct {
    int    kind;   // 0 rx byte, 1 done, 2 mismatch
    int    val;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic seen(input int kind, input int val);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk("unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk({e.tag, " kind"}, kind, e.kind);
      if (kind == 0) chk({e.tag, " data"}, val, e.val);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) seen(0, int'(rx_data));
      if (done)     seen(1, 0);
      if (mismatch) seen(2, 0);
    end
  end

  task automatic set_lines(input logic [2:0] ph);
    @(negedge clk);
    {bus_msg_i, bus_cd_i, bus_io_i} = ph;
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] ph, input int n, input logic tgt);
    @(negedge clk);
    req_phase = ph; byte_count = CNT_W'(n); target_mode = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic tgt_byte(input logic [7:0] d, input bit hold,
                          output logic [7:0] got, output logic oe, output logic atn);
    @(negedge clk);
    bus_data_i = d; bus_req_i = 1'b1;
    do @(negedge clk); while (!bus_ack_o);
    got = bus_data_o; oe = bus_data_oe; atn = bus_atn_o;
    bus_req_i = 1'b0;
    if (!hold) begin
      do @(negedge clk); while (bus_ack_o);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] g;
    logic oe, at;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ack", bus_ack_o, 0);
    chk("R9 atn", bus_atn_o, 0);
    chk("R9 data_oe", bus_data_oe, 0);
    chk("R9 phase_oe", bus_phase_oe, 0);
    chk("R9 pulses", {done, mismatch, rx_valid}, 0);

    // Data-In, three bytes: R3 capture, R2 sequence, R5 done
    set_lines(3'b001);
    push(0, 8'hA5, "R3 byte0");
    push(0, 8'h3C, "R3 byte1");
    push(0, 8'h0F, "R3 byte2");
    push(1, 0, "R5 datain done");
    issue(3'b001, 3, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 no ack before req", bus_ack_o, 0);
    tgt_byte(8'hA5, 0, g, oe, at);
    chk("R4 no drive inbound", oe, 0);
    chk("R2 ack released", bus_ack_o, 0);
    tgt_byte(8'h3C, 0, g, oe, at);
    tgt_byte(8'h0F, 0, g, oe, at);
    repeat (3) @(negedge clk);

    // Data-Out, two bytes: R4
    set_lines(3'b000);
    push(1, 0, "R5 dataout done");
    issue(3'b000, 2, 1'b0);
    tx_data = 8'h11;
    tgt_byte(8'h00, 0, g, oe, at);
    chk("R4 out byte0", g, 8'h11);
    chk("R4 drive outbound", oe, 1);
    tx_data = 8'h22;
    tgt_byte(8'h00, 0, g, oe, at);
    chk("R4 out byte1", g, 8'h22);
    repeat (3) @(negedge clk);
    chk("R4 oe released", bus_data_oe, 0);

    // mismatch: lines Status, request Data-In
    set_lines(3'b011);
    push(2, 0, "R1 mismatch");
    issue(3'b001, 2, 1'b0);
    repeat (5) @(negedge clk);
    chk("R1 no ack on mismatch", bus_ack_o, 0);

    // zero count
    set_lines(3'b010);
    push(1, 0, "R5 zero count done");
    issue(3'b010, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 zero count no ack", bus_ack_o, 0);

    // Message-Out with ATN
    @(negedge clk); set_atn = 1'b1;
    @(negedge clk); set_atn = 1'b0;
    @(negedge clk);
    chk("R6 atn set", bus_atn_o, 1);
    set_lines(3'b110);
    push(1, 0, "R6 msgout done");
    issue(3'b110, 2, 1'b0);
    tx_data = 8'hC0;
    tgt_byte(8'h00, 0, g, oe, at);
    chk("R6 atn kept first byte", at, 1);
    tx_data = 8'h07;
    tgt_byte(8'h00, 0, g, oe, at);
    chk("R6 atn dropped at final ack", at, 0);
    chk("R4 msgout byte1", g, 8'h07);

    // Message-In: ACK held
    set_lines(3'b111);
    push(0, 8'h81, "R3 msgin byte0");
    push(0, 8'h04, "R3 msgin byte1");
    push(1, 0, "R7 msgin done");
    issue(3'b111, 2, 1'b0);
    tgt_byte(8'h81, 0, g, oe, at);
    tgt_byte(8'h04, 1, g, oe, at);
    repeat (4) @(negedge clk);
    chk("R7 ack held", bus_ack_o, 1);
    clear_ack = 1'b1;
    @(negedge clk);
    clear_ack = 1'b0;
    chk("R7 ack cleared", bus_ack_o, 0);

    // target mode
    push(1, 0, "R8 target done");
    issue(3'b010, 5, 1'b1);
    @(negedge clk);
    chk("R8 phase lines", {bus_msg_o, bus_cd_o, bus_io_o}, 3'b010);
    chk("R8 phase oe", bus_phase_oe, 1);
    chk("R8 no ack", bus_ack_o, 0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule